// File: doc/BRIEF.md
# Two-Phase Recovery Point Sequencer

This block runs the local half of a global checkpoint for one node of a shared-memory machine. It keeps the node's line state tags in step with a two-phase commit led by a coordinator. A checkpoint request first waits for the node's outstanding coherence traffic to drain. The block then sweeps the tag array once, and for every line written since the last recovery point it asks a neighbour node to hold a second copy before it marks the local copy Precommit. It then raises create-done and waits for the coordinator's global go. A second sweep then confirms the new recovery point on its own, with no messages.

A failure notice throws the node back to the last confirmed recovery point with a rollback sweep. A notice that arrives before commit starts rolls back at once, because the old point is still whole. A notice that lands in the middle of a commit sweep is held until that sweep has finished. Only the tag array is touched here. Moving the data and storing the remote copies belong to the neighbours of this block.

Top module: `recovery_point_seq`

## Requirements
- R1: A pulse on ckptReq in IDLE moves phase to DRAIN. DRAIN holds while pendingBusy is 1 and moves to CREATE on the first cycle that pendingBusy is 0.
- R2: In CREATE one line is visited per cycle. A line whose tag is 3 (modified, sole copy) or 2 (owned, readable) raises repReq with repAddr equal to its index and stalls until repAck. It is then written to 6 (Precommit). All other tags are left as they are.
- R3: While repReq is high, repReuse is 1 exactly when the tag is 2 and tagSharers is 1. This is the case where an existing replica is promoted and no data moves.
- R4: After the last line of the create sweep, phase is WAIT_GO and createDone stays high until commitGo is sampled.
- R5: A commitGo in WAIT_GO starts a COMMIT sweep of one line per cycle. It maps 5 (checkpoint invalid) to 0 and 6 to 4 (checkpoint shared) and leaves all other tags unchanged. It never raises repReq and returns to IDLE after the last line.
- R6: failNotice in IDLE, DRAIN, CREATE or WAIT_GO moves phase to ROLLBACK on the next cycle. It wins over a ckptReq or a repAck in the same cycle.
- R7: A ROLLBACK sweep of one line per cycle maps 1, 2, 3 and 6 to 0 and 5 to 4, and leaves 0 and 4 as they are. It returns to IDLE after the last line.
- R8: A failNotice seen during COMMIT does not stop the sweep. The commit mapping finishes on every line, and the next phase is ROLLBACK instead of IDLE.
- R9: The phase code is IDLE=0, DRAIN=1, CREATE=2, WAIT_GO=3, COMMIT=4, ROLLBACK=5. After reset the phase is IDLE and createDone, repReq and tagWrEn are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ckptReq | input | 1 | Coordinator asks for a new recovery point |
| pendingBusy | input | 1 | Node still has coherence requests in flight |
| commitGo | input | 1 | Coordinator: all nodes have finished create |
| failNotice | input | 1 | Broadcast failure notice |
| createDone | output | 1 | Local create sweep finished, waiting for go |
| phase | output | 3 | Current phase code (R9) |
| tagAddr | output | ADDR_W | Index of the line being visited |
| tagRdData | input | 3 | Tag of the addressed line (combinational read) |
| tagSharers | input | 1 | Addressed line has read-only replicas elsewhere |
| tagWrEn | output | 1 | Write the new tag at the rising edge |
| tagWrData | output | 3 | New tag value |
| repReq | output | 1 | Ask for a second Precommit copy of the line |
| repAddr | output | ADDR_W | Line index of the replicate request |
| repReuse | output | 1 | Promote an existing replica instead of copying |
| repAck | input | 1 | Replicate request is done |

## Verification
Two things can fall in the same cycle. A failure notice can coincide with a checkpoint request or a replicate acknowledge. A failure notice can also arrive part-way through the commit sweep. The bench raises failNotice and ckptReq on one edge and expects ROLLBACK. It also drops a failure into a create sweep that is stalled on a delayed acknowledge. In both cases the final tag array must equal the rollback mapping of the starting tags. For the commit case, it injects the notice three lines into the sweep. It then checks that the full commit mapping is in place when ROLLBACK begins, and that the rollback of that result is what stays at the end.

// File: rtl/rps_pkg.sv
package rps_pkg;

  localparam logic [2:0] LS_INV = 3'd0;
  localparam logic [2:0] LS_SHR = 3'd1;
  localparam logic [2:0] LS_NXO = 3'd2;
  localparam logic [2:0] LS_MOD = 3'd3;
  localparam logic [2:0] LS_SCK = 3'd4;
  localparam logic [2:0] LS_ICK = 3'd5;
  localparam logic [2:0] LS_PRE = 3'd6;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_DRAIN    = 3'd1,
    PH_CREATE   = 3'd2,
    PH_WAITGO   = 3'd3,
    PH_COMMIT   = 3'd4,
    PH_ROLLBACK = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    MAP_CREATE = 2'd0,
    MAP_COMMIT = 2'd1,
    MAP_ROLL   = 2'd2
  } mapSel_e;

  typedef struct packed {
    logic    clrAddr;
    logic    stepAddr;
    logic    wrAllow;
    mapSel_e mapSel;
  } ctrlStrb_t;

  function automatic logic [2:0] mapLine(mapSel_e sel, logic [2:0] s);
    logic [2:0] r;
    r = s;
    case (sel)
      MAP_CREATE: if (s == LS_MOD || s == LS_NXO) r = LS_PRE;
      MAP_COMMIT: begin
        if (s == LS_ICK) r = LS_INV;
        else if (s == LS_PRE) r = LS_SCK;
      end
      MAP_ROLL: begin
        if (s == LS_ICK) r = LS_SCK;
        else if (s != LS_SCK) r = LS_INV;
      end
      default: r = s;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rps_dpath.sv
module rps_dpath
  import rps_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [2:0]        tagRdData,
  input  logic              tagSharers,
  output logic [ADDR_W-1:0] tagAddr,
  output logic              tagWrEn,
  output logic [2:0]        tagWrData,
  output logic              lastLine,
  output logic              lineDirty,
  output logic              lineReuse
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_LINES - 1);

  logic [ADDR_W-1:0] lineIdx;

  always_ff @(posedge clk) begin
    if (!rstN)              lineIdx <= '0;
    else if (strb.clrAddr)  lineIdx <= '0;
    else if (strb.stepAddr) lineIdx <= lineIdx + 1'b1;
  end

  assign tagAddr   = lineIdx;
  assign lastLine  = (lineIdx == LAST_IDX);
  assign lineDirty = (tagRdData == LS_MOD) || (tagRdData == LS_NXO);
  assign lineReuse = (tagRdData == LS_NXO) && tagSharers;
  assign tagWrData = mapLine(strb.mapSel, tagRdData);
  assign tagWrEn   = strb.wrAllow && (tagWrData != tagRdData);

endmodule

// File: rtl/rps_ctrl.sv
module rps_ctrl
  import rps_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ckptReq,
  input  logic      pendingBusy,
  input  logic      commitGo,
  input  logic      failNotice,
  input  logic      repAck,
  input  logic      lastLine,
  input  logic      lineDirty,
  output phase_e    phase,
  output ctrlStrb_t strb,
  output logic      repReq,
  output logic      createDone
);

  phase_e nextPhase;
  logic   failHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      failHeld <= 1'b0;
    end else begin
      phase <= nextPhase;
      if (phase == PH_COMMIT) failHeld <= failHeld | failNotice;
      else                    failHeld <= 1'b0;
    end
  end

  always_comb begin
    nextPhase     = phase;
    strb          = '{clrAddr: 1'b0, stepAddr: 1'b0, wrAllow: 1'b0, mapSel: MAP_CREATE};
    repReq        = 1'b0;
    case (phase)
      PH_IDLE: begin
        strb.clrAddr = 1'b1;
        if (failNotice)   nextPhase = PH_ROLLBACK;
        else if (ckptReq) nextPhase = PH_DRAIN;
      end
      PH_DRAIN: begin
        strb.clrAddr = 1'b1;
        if (failNotice)        nextPhase = PH_ROLLBACK;
        else if (!pendingBusy) nextPhase = PH_CREATE;
      end
      PH_CREATE: begin
        strb.mapSel = MAP_CREATE;
        if (failNotice) begin
          nextPhase    = PH_ROLLBACK;
          strb.clrAddr = 1'b1;
        end else begin
          repReq = lineDirty;
          if (!lineDirty || repAck) begin
            strb.wrAllow  = lineDirty;
            strb.stepAddr = 1'b1;
            if (lastLine) begin
              strb.clrAddr = 1'b1;
              nextPhase    = PH_WAITGO;
            end
          end
        end
      end
      PH_WAITGO: begin
        strb.clrAddr = 1'b1;
        if (failNotice)    nextPhase = PH_ROLLBACK;
        else if (commitGo) nextPhase = PH_COMMIT;
      end
      PH_COMMIT: begin
        strb.mapSel   = MAP_COMMIT;
        strb.wrAllow  = 1'b1;
        strb.stepAddr = 1'b1;
        if (lastLine) begin
          strb.clrAddr = 1'b1;
          nextPhase    = (failHeld || failNotice) ? PH_ROLLBACK : PH_IDLE;
        end
      end
      PH_ROLLBACK: begin
        strb.mapSel   = MAP_ROLL;
        strb.wrAllow  = 1'b1;
        strb.stepAddr = 1'b1;
        if (lastLine) begin
          strb.clrAddr = 1'b1;
          nextPhase    = PH_IDLE;
        end
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  assign createDone = (phase == PH_WAITGO);

endmodule

// File: rtl/recovery_point_seq.sv
module recovery_point_seq
  import rps_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int ADDR_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ckptReq,
  input  logic              pendingBusy,
  input  logic              commitGo,
  input  logic              failNotice,
  output logic              createDone,
  output logic [2:0]        phase,
  output logic [ADDR_W-1:0] tagAddr,
  input  logic [2:0]        tagRdData,
  input  logic              tagSharers,
  output logic              tagWrEn,
  output logic [2:0]        tagWrData,
  output logic              repReq,
  output logic [ADDR_W-1:0] repAddr,
  output logic              repReuse,
  input  logic              repAck
);

  ctrlStrb_t strb;
  phase_e    phaseQ;
  logic      lastLine;
  logic      lineDirty;
  logic      lineReuse;

  rps_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ckptReq    (ckptReq),
    .pendingBusy(pendingBusy),
    .commitGo   (commitGo),
    .failNotice (failNotice),
    .repAck     (repAck),
    .lastLine   (lastLine),
    .lineDirty  (lineDirty),
    .phase      (phaseQ),
    .strb       (strb),
    .repReq     (repReq),
    .createDone (createDone)
  );

  rps_dpath #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .tagRdData (tagRdData),
    .tagSharers(tagSharers),
    .tagAddr   (tagAddr),
    .tagWrEn   (tagWrEn),
    .tagWrData (tagWrData),
    .lastLine  (lastLine),
    .lineDirty (lineDirty),
    .lineReuse (lineReuse)
  );

  assign phase    = phaseQ;
  assign repAddr  = tagAddr;
  assign repReuse = repReq & lineReuse;

endmodule

// File: rtl/recovery_point_seq_chk.sv
module recovery_point_seq_chk
  import rps_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              ckptReq,
  input logic              pendingBusy,
  input logic              commitGo,
  input logic              failNotice,
  input logic              createDone,
  input logic [2:0]        phase,
  input logic [ADDR_W-1:0] tagAddr,
  input logic              tagWrEn,
  input logic [2:0]        tagWrData,
  input logic              repReq,
  input logic              repReuse,
  input logic              repAck
);

  p_drain_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DRAIN && pendingBusy && !failNotice) |=> (phase == PH_DRAIN));

  p_req_in_create_r2: assert property (@(posedge clk) disable iff (!rstN)
    repReq |-> (phase == PH_CREATE));

  p_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (repReq && !repAck && !failNotice) |=> $stable(tagAddr));

  p_create_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CREATE && tagWrEn) |-> (tagWrData == LS_PRE && repAck));

  p_reuse_r3: assert property (@(posedge clk) disable iff (!rstN)
    repReuse |-> repReq);

  p_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    createDone |-> (phase == PH_WAITGO));

  p_commit_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_COMMIT && tagWrEn) |-> (tagWrData == LS_INV || tagWrData == LS_SCK));

  p_fail_r6: assert property (@(posedge clk) disable iff (!rstN)
    (failNotice && phase <= PH_WAITGO) |=> (phase == PH_ROLLBACK));

  p_roll_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ROLLBACK && tagWrEn) |-> (tagWrData == LS_INV || tagWrData == LS_SCK));

  p_phase_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    phase <= PH_ROLLBACK);

endmodule

bind recovery_point_seq recovery_point_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ckptReq    (ckptReq),
  .pendingBusy(pendingBusy),
  .commitGo   (commitGo),
  .failNotice (failNotice),
  .createDone (createDone),
  .phase      (phase),
  .tagAddr    (tagAddr),
  .tagWrEn    (tagWrEn),
  .tagWrData  (tagWrData),
  .repReq     (repReq),
  .repReuse   (repReuse),
  .repAck     (repAck)
);

// File: tb/recovery_point_seq_tb.sv
`timescale 1ns/1ps
module recovery_point_seq_tb;

  localparam int N = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ckptReq = 1'b0, pendingBusy = 1'b0, commitGo = 1'b0, failNotice = 1'b0;
  logic createDone, tagWrEn, tagSharers, repReq, repReuse;
  logic repAck = 1'b0;
  logic [2:0] phase, tagRdData, tagWrData;
  logic [AW-1:0] tagAddr, repAddr;

  logic [2:0] mem [N];
  logic       shr [N];
  int         orig [N];
  int         errors = 0, checks = 0, grants = 0, lat = 0, ackCnt = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  recovery_point_seq #(.NUM_LINES(N)) u_dut (
    .clk(clk), .rstN(rstN), .ckptReq(ckptReq), .pendingBusy(pendingBusy),
    .commitGo(commitGo), .failNotice(failNotice), .createDone(createDone),
    .phase(phase), .tagAddr(tagAddr), .tagRdData(tagRdData), .tagSharers(tagSharers),
    .tagWrEn(tagWrEn), .tagWrData(tagWrData), .repReq(repReq), .repAddr(repAddr),
    .repReuse(repReuse), .repAck(repAck)
  );

  assign tagRdData  = mem[tagAddr];
  assign tagSharers = shr[tagAddr];

  always @(posedge clk) if (tagWrEn) mem[tagAddr] <= tagWrData;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // replicate responder: acknowledges after lat idle cycles, checks R3 reuse flag
  always @(negedge clk) begin
    if (!rstN) begin
      repAck <= 1'b0; ackCnt <= 0;
    end else if (repAck) begin
      repAck <= 1'b0;
    end else if (repReq) begin
      check(repReuse == ((orig[tagAddr] == 2) && shr[tagAddr]), "R3 reuse flag",
            int'(repReuse), int'((orig[tagAddr] == 2) && shr[tagAddr]));
      check(repAddr == tagAddr && (orig[tagAddr] == 2 || orig[tagAddr] == 3),
            "R2 request line", int'(repAddr), int'(tagAddr));
      if (ackCnt >= lat) begin
        repAck <= 1'b1; ackCnt <= 0; grants++;
      end else ackCnt <= ackCnt + 1;
    end
  end

  function automatic int fCreate(int s);
    return (s == 2 || s == 3) ? 6 : s;
  endfunction
  function automatic int fCommit(int s);
    return (s == 5) ? 0 : (s == 6) ? 4 : s;
  endfunction
  function automatic int fRoll(int s);
    return (s == 5) ? 4 : (s == 4) ? 4 : 0;
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(int seed);
    for (int i = 0; i < N; i++) begin
      mem[i]  = 3'((i * 3 + seed) % 7);
      orig[i] = (i * 3 + seed) % 7;
      shr[i]  = ((i + seed) % 2) == 1;
    end
  endtask

  // ops bit0 create, bit1 commit, bit2 rollback, applied in that order
  task automatic checkMem(string req, int ops);
    for (int i = 0; i < N; i++) begin
      int e;
      e = orig[i];
      if (ops[0]) e = fCreate(e);
      if (ops[1]) e = fCommit(e);
      if (ops[2]) e = fRoll(e);
      check(int'(mem[i]) == e, req, int'(mem[i]), e);
    end
  endtask

  task automatic waitPhase(int p, int lim);
    int k;
    k = 0;
    while (int'(phase) != p && k < lim) begin tick(); k++; end
    check(int'(phase) == p, "R4 phase reached", int'(phase), p);
  endtask

  function automatic int dirtyCount();
    int c;
    c = 0;
    for (int i = 0; i < N; i++) if (orig[i] == 2 || orig[i] == 3) c++;
    return c;
  endfunction

  task automatic enterCreate(int drainCycles);
    pendingBusy = 1'b1; ckptReq = 1'b1; tick(); ckptReq = 1'b0;
    check(phase == 3'd1, "R1 drain entered", int'(phase), 1);
    tick(drainCycles);
    check(phase == 3'd1, "R1 drain held", int'(phase), 1);
    pendingBusy = 1'b0; tick();
    check(phase == 3'd2, "R1 create after drain", int'(phase), 2);
  endtask

  task automatic establish(int seed, int latency, int drainCycles);
    load(seed); lat = latency; grants = 0;
    enterCreate(drainCycles);
    waitPhase(3, 200);
    check(createDone == 1'b1, "R4 createDone", int'(createDone), 1);
    check(grants == dirtyCount(), "R2 request count", grants, dirtyCount());
    checkMem("R2 create map", 1);
    tick(3);
    check(phase == 3'd3 && createDone, "R4 waits for go", int'(phase), 3);
    commitGo = 1'b1; tick(); commitGo = 1'b0;
    check(phase == 3'd4, "R5 commit entered", int'(phase), 4);
    tick(N);
    check(phase == 3'd0, "R5 idle after commit", int'(phase), 0);
    checkMem("R5 commit map", 3);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired (R1..R9 run incomplete) actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    load(0);
    tick(3);
    check(phase == 3'd0, "R9 reset phase", int'(phase), 0);
    check(!createDone && !repReq && !tagWrEn, "R9 reset outputs",
          int'({createDone, repReq, tagWrEn}), 0);
    rstN = 1'b1; tick();
    check(phase == 3'd0, "R9 idle after reset", int'(phase), 0);

    for (int s = 0; s < 7; s++) establish(s, s % 3, s % 4);

    // R2: a sweep with no dirty lines takes exactly one cycle per line
    for (int i = 0; i < N; i++) begin
      orig[i] = (i % 2 == 0) ? 4 : ((i % 4 == 1) ? 5 : 1);
      mem[i]  = 3'(orig[i]); shr[i] = 1'b0;
    end
    pendingBusy = 1'b0; ckptReq = 1'b1; tick(); ckptReq = 1'b0; tick();
    check(phase == 3'd2, "R1 create after empty drain", int'(phase), 2);
    tick(N - 1);
    check(phase == 3'd2, "R2 one line per cycle", int'(phase), 2);
    tick();
    check(phase == 3'd3, "R2 sweep length", int'(phase), 3);
    commitGo = 1'b1; tick(); commitGo = 1'b0; tick(N);
    checkMem("R5 commit of clean lines", 3);

    // R7: rollback from idle
    load(1);
    failNotice = 1'b1; tick(); failNotice = 1'b0;
    check(phase == 3'd5, "R7 rollback entered", int'(phase), 5);
    tick(N);
    check(phase == 3'd0, "R7 idle after rollback", int'(phase), 0);
    checkMem("R7 rollback map", 4);

    // R6: failure and checkpoint request on the same edge
    load(2);
    failNotice = 1'b1; ckptReq = 1'b1; tick(); failNotice = 1'b0; ckptReq = 1'b0;
    check(phase == 3'd5, "R6 fail beats ckptReq", int'(phase), 5);
    tick(N);
    checkMem("R6 rollback after collision", 4);

    // R6: failure while a replicate request is stalled
    load(3); lat = 2;
    enterCreate(1);
    tick(3);
    failNotice = 1'b1; tick(); failNotice = 1'b0;
    check(phase == 3'd5, "R6 fail during create", int'(phase), 5);
    tick(N);
    check(phase == 3'd0, "R6 idle after create abort", int'(phase), 0);
    checkMem("R6 old point restored", 4);

    // R6: failure while waiting for go
    load(4); lat = 0;
    enterCreate(0);
    waitPhase(3, 200);
    failNotice = 1'b1; tick(); failNotice = 1'b0;
    check(phase == 3'd5, "R6 fail in wait_go", int'(phase), 5);
    tick(N);
    checkMem("R6 rollback from wait_go", 5);

    // R8: failure in the middle of commit
    load(5); lat = 1;
    enterCreate(2);
    waitPhase(3, 200);
    commitGo = 1'b1; tick(); commitGo = 1'b0;
    tick(2);
    failNotice = 1'b1; tick(); failNotice = 1'b0;
    check(phase == 3'd4, "R8 commit continues", int'(phase), 4);
    tick(N - 3);
    check(phase == 3'd5, "R8 rollback after commit", int'(phase), 5);
    checkMem("R8 commit completed first", 3);
    tick(N);
    check(phase == 3'd0, "R8 idle at end", int'(phase), 0);
    checkMem("R8 rollback of committed point", 7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule